// File: doc/BRIEF.md
# Same-ID Write Response Ordering Unit

This unit sits on the write path of an interconnect, between a single write master and two write targets. Each write address is steered to one target by a single address bit. For every transaction identifier the unit records, in issue order, which target took each write, so that it always knows which target owes the next completion for that identifier.

Targets may finish writes in any order. A completion is forwarded to the master only when its target is the one owed for that identifier. A completion that arrives early is left waiting in the target, which sees its ready held low. Completions for different identifiers are independent. When two targets hold forwardable completions in the same cycle, a two-way round-robin picks one of them. Each identifier can have only a bounded number of writes outstanding. New addresses for an identifier whose record is full are refused, and other identifiers continue to flow.

Top module: `wr_resp_order`

## Requirements
- R1: While reset is applied, and until the internal synchronized reset releases, `m_b_valid`, `s_aw_valid` and `s_b_ready` are all zero and `m_aw_ready` is low. Tracking for every identifier restarts empty.
- R2: Address bit `SEL_BIT` (default 12) selects the target: 0 drives `s_aw_valid[0]` and 1 drives `s_aw_valid[1]`. `s_aw_id` and `s_aw_addr` carry the master's values unchanged.
- R3: For any one identifier, completions reach the master in the order their addresses were accepted, whatever the split of those writes between the two targets.
- R4: A target presenting a completion for an identifier whose oldest outstanding write went to the other target sees `s_b_ready` low, and that completion is not forwarded.
- R5: Completions for different identifiers are not ordered against each other. A completion for one identifier is forwarded while older writes of another identifier are still outstanding.
- R6: With `DEPTH` (default 4) writes outstanding for an identifier, `m_aw_ready` is low and no `s_aw_valid` is raised for a new address with that identifier. Other identifiers are still accepted, and one completion for that identifier frees a slot.
- R7: When both targets hold forwardable completions, the grant alternates. After reset target 0 is served first, and after any handshake the target not just served is preferred.
- R8: `m_b_id` and `m_b_resp` equal the `s_b_id` and `s_b_resp` fields of the granted target.
- R9: With `m_b_ready` low, both `s_b_ready` bits are low and nothing is retired. The same completion is still offered on the next cycle.
- R10: `m_aw_ready` follows the selected target's `s_aw_ready`. A stalled target blocks acceptance even when the identifier has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_aw_valid | input | 1 | Master write address valid |
| m_aw_ready | output | 1 | Master write address ready |
| m_aw_id | input | IDW | Master write identifier |
| m_aw_addr | input | AW | Master write address |
| s_aw_valid | output | 2 | Per-target write address valid (bit n for target n) |
| s_aw_ready | input | 2 | Per-target write address ready |
| s_aw_id | output | IDW | Identifier shared by both targets |
| s_aw_addr | output | AW | Address shared by both targets |
| s_b_valid | input | 2 | Per-target completion valid |
| s_b_ready | output | 2 | Per-target completion ready |
| s_b_id | input | 2*IDW | Completion identifiers, target n in bits [n*IDW +: IDW] |
| s_b_resp | input | 2*RW | Completion codes, target n in bits [n*RW +: RW] |
| m_b_valid | output | 1 | Master completion valid |
| m_b_ready | input | 1 | Master completion ready |
| m_b_id | output | IDW | Master completion identifier |
| m_b_resp | output | RW | Master completion code |

## Verification
The bench sweeps every identifier with every split of three writes across the two targets. Each cycle both targets offer their oldest completion, so a unit that ignored the recorded destination would return a later write first, or grant a target that is not owed. Separate cases exercise the following:
- an early completion from the wrong target, which a faulty unit would pass straight through;
- a full identifier, where an off-by-one depth check would accept a fifth write or refuse the fourth;
- a simultaneous grant sequence that exposes a fixed-priority arbiter;
- master backpressure, where a faulty unit would retire a completion that was never taken.

// File: rtl/wro_pkg.sv
package wro_pkg;
  localparam int unsigned NSLV = 2;
  typedef logic [NSLV-1:0] slv_vec_t;
endpackage

// File: rtl/wro_rst_sync.sv
module wro_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/wro_dest_fifo.sv
module wro_dest_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] mem_q [DEPTH];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (!push && pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= push_data;
  end

  assign head  = mem_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/wro_rr2.sv
module wro_rr2 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       advance,
  output logic [1:0] gnt
);
  logic last_q, last_d;

  always_comb begin
    if (&req) gnt = last_q ? 2'b01 : 2'b10;
    else      gnt = req;
    last_d = (advance && |gnt) ? gnt[1] : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_d;
  end
endmodule

// File: rtl/wr_resp_order.sv
module wr_resp_order
  import wro_pkg::*;
#(
  parameter int unsigned IDW     = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned RW      = 2,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned SEL_BIT = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m_aw_valid,
  output logic                 m_aw_ready,
  input  logic [IDW-1:0]       m_aw_id,
  input  logic [AW-1:0]        m_aw_addr,
  output logic [NSLV-1:0]      s_aw_valid,
  input  logic [NSLV-1:0]      s_aw_ready,
  output logic [IDW-1:0]       s_aw_id,
  output logic [AW-1:0]        s_aw_addr,
  input  logic [NSLV-1:0]      s_b_valid,
  output logic [NSLV-1:0]      s_b_ready,
  input  logic [NSLV*IDW-1:0]  s_b_id,
  input  logic [NSLV*RW-1:0]   s_b_resp,
  output logic                 m_b_valid,
  input  logic                 m_b_ready,
  output logic [IDW-1:0]       m_b_id,
  output logic [RW-1:0]        m_b_resp
);
  localparam int unsigned NID = 1 << IDW;

  logic           rst_q;
  logic [NID-1:0] head_w, empty_w, full_w;
  logic           aw_sel, id_full, aw_hs, b_hs, gsel;
  slv_vec_t       elig, gnt;

  wro_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  // Address side: route by one address bit, refuse when the ID record is full
  assign aw_sel     = m_aw_addr[SEL_BIT];
  assign id_full    = full_w[m_aw_id];
  assign s_aw_valid = (rst_q && m_aw_valid && !id_full) ? (aw_sel ? 2'b10 : 2'b01) : 2'b00;
  assign m_aw_ready = rst_q && !id_full && s_aw_ready[aw_sel];
  assign aw_hs      = m_aw_valid && m_aw_ready;
  assign s_aw_id    = m_aw_id;
  assign s_aw_addr  = m_aw_addr;

  // One destination record per identifier
  for (genvar i = 0; i < NID; i++) begin : g_id
    wro_dest_fifo #(.DEPTH(DEPTH), .DW(1)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_q),
      .push      (aw_hs && (m_aw_id == IDW'(i))),
      .push_data (aw_sel),
      .pop       (b_hs && (m_b_id == IDW'(i))),
      .head      (head_w[i]),
      .empty     (empty_w[i]),
      .full      (full_w[i])
    );
  end

  // Completion side: a target is eligible only when it is owed for that ID
  for (genvar s = 0; s < NSLV; s++) begin : g_slv
    logic [IDW-1:0] bid;
    assign bid     = s_b_id[s*IDW +: IDW];
    assign elig[s] = s_b_valid[s] && !empty_w[bid] && (head_w[bid] == 1'(s));
  end

  wro_rr2 u_arb (
    .clk     (clk),
    .rst_n   (rst_q),
    .req     (elig),
    .advance (b_hs),
    .gnt     (gnt)
  );

  assign gsel      = gnt[1];
  assign m_b_valid = |gnt;
  assign m_b_id    = gsel ? s_b_id[2*IDW-1:IDW] : s_b_id[IDW-1:0];
  assign m_b_resp  = gsel ? s_b_resp[2*RW-1:RW] : s_b_resp[RW-1:0];
  assign s_b_ready = gnt & {NSLV{m_b_ready}};
  assign b_hs      = m_b_valid && m_b_ready;
endmodule

// File: rtl/wro_chk.sv
module wro_chk #(
  parameter int unsigned IDW     = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned RW      = 2,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned SEL_BIT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_aw_valid,
  input logic              m_aw_ready,
  input logic [IDW-1:0]    m_aw_id,
  input logic [AW-1:0]     m_aw_addr,
  input logic [1:0]        s_aw_valid,
  input logic [1:0]        s_aw_ready,
  input logic [AW-1:0]     s_aw_addr,
  input logic [1:0]        s_b_ready,
  input logic [2*IDW-1:0]  s_b_id,
  input logic [2*RW-1:0]   s_b_resp,
  input logic              m_b_valid,
  input logic              m_b_ready,
  input logic [IDW-1:0]    m_b_id,
  input logic [RW-1:0]     m_b_resp
);
  localparam int unsigned NID = 1 << IDW;
  localparam int unsigned CW  = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] out_q [NID];
  logic [CW-1:0] out_d [NID];

  always_comb begin
    for (int i = 0; i < NID; i++) begin
      out_d[i] = out_q[i];
      if (m_aw_valid && m_aw_ready && m_aw_id == IDW'(i)) out_d[i] = out_d[i] + 1'b1;
      if (m_b_valid && m_b_ready && m_b_id == IDW'(i))    out_d[i] = out_d[i] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < NID; i++) out_q[i] <= '0;
    else        for (int i = 0; i < NID; i++) out_q[i] <= out_d[i];
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!m_b_valid && s_aw_valid == 2'b00 && s_b_ready == 2'b00 && !m_aw_ready)); // R1
  AST_ROUTE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) s_aw_valid[1] |-> s_aw_addr[SEL_BIT]); // R2
  AST_ROUTE_LOW: assert property (@(posedge clk) disable iff (!rst_n) s_aw_valid[0] |-> !s_aw_addr[SEL_BIT]); // R2
  AST_NO_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n) (m_b_valid && m_b_ready) |-> out_q[m_b_id] != '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (m_aw_valid && m_aw_ready) |-> out_q[m_aw_id] < CW'(DEPTH)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n) (out_q[m_aw_id] == CW'(DEPTH)) |-> (!m_aw_ready && s_aw_valid == 2'b00)); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(s_b_ready)); // R7
  AST_PASS_T0: assert property (@(posedge clk) disable iff (!rst_n) s_b_ready[0] |-> (m_b_valid && m_b_id == s_b_id[IDW-1:0] && m_b_resp == s_b_resp[RW-1:0])); // R8
  AST_PASS_T1: assert property (@(posedge clk) disable iff (!rst_n) s_b_ready[1] |-> (m_b_valid && m_b_id == s_b_id[2*IDW-1:IDW] && m_b_resp == s_b_resp[2*RW-1:RW])); // R8
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n) !m_b_ready |-> s_b_ready == 2'b00); // R9
  AST_AW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) m_aw_ready |-> s_aw_ready[m_aw_addr[SEL_BIT]]); // R10
endmodule

bind wr_resp_order wro_chk #(
  .IDW(IDW), .AW(AW), .RW(RW), .DEPTH(DEPTH), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_q),
  .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_id(m_aw_id), .m_aw_addr(m_aw_addr),
  .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_addr(s_aw_addr),
  .s_b_ready(s_b_ready), .s_b_id(s_b_id), .s_b_resp(s_b_resp),
  .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_id(m_b_id), .m_b_resp(m_b_resp)
);

// File: tb/sim_wr_resp_order.sv
module sim_wr_resp_order;
  logic        clk, rst_n;
  logic        m_aw_valid, m_aw_ready;
  logic [1:0]  m_aw_id;
  logic [31:0] m_aw_addr;
  logic [1:0]  s_aw_valid, s_aw_ready;
  logic [1:0]  s_aw_id;
  logic [31:0] s_aw_addr;
  logic [1:0]  s_b_valid, s_b_ready;
  logic [3:0]  s_b_id, s_b_resp;
  logic        m_b_valid, m_b_ready;
  logic [1:0]  m_b_id, m_b_resp;

  int n_chk = 0;
  int n_fail = 0;
  int dest [3];
  int k;

  wr_resp_order u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_aw_valid = 1'b1; m_aw_id = 2'd1; m_aw_addr = 32'h1000;
    s_b_valid = 2'b11; s_b_id = 4'b0000;
    #2;
    chk("R1 m_b_valid", int'(m_b_valid), 0);
    chk("R1 s_aw_valid", int'(s_aw_valid), 0);
    chk("R1 s_b_ready", int'(s_b_ready), 0);
    chk("R1 m_aw_ready", int'(m_aw_ready), 0);
    repeat (2) @(negedge clk);
    m_aw_valid = 1'b0; s_b_valid = 2'b00;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] addr_for(input int id, input int sel);
    return 32'h0004_0000 | (32'(sel) << 12) | (32'(id) << 4);
  endfunction

  task automatic do_aw(input int id, input int sel, input int exp_rdy, input string req);
    @(negedge clk);
    m_aw_valid = 1'b1; m_aw_id = 2'(id); m_aw_addr = addr_for(id, sel);
    #2;
    chk({req, " aw_ready"}, int'(m_aw_ready), exp_rdy);
    if (exp_rdy == 1) begin
      chk("R2 s_aw_valid", int'(s_aw_valid), (sel == 1) ? 2 : 1);
      chk("R2 s_aw_addr", int'(s_aw_addr == addr_for(id, sel)), 1);
      chk("R2 s_aw_id", int'(s_aw_id), id);
    end
    @(posedge clk);
    #1 m_aw_valid = 1'b0;
  endtask

  function automatic int next_for(input int s);
    for (int j = k; j < 3; j++) if (dest[j] == s) return j;
    return 3;
  endfunction

  // Offer one completion from target s and check it is forwarded
  task automatic one_b(input int s, input int id, input int resp, input string req);
    @(negedge clk);
    s_b_valid = 2'(1 << s);
    s_b_id = 4'(id << (2 * s));
    s_b_resp = 4'(resp << (2 * s));
    #2;
    chk({req, " fwd"}, int'(s_b_ready), 1 << s);
    chk("R8 id", int'(m_b_id), id);
    chk("R8 resp", int'(m_b_resp), resp);
    @(posedge clk);
    #1 s_b_valid = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; m_aw_valid = 1'b0; m_aw_id = '0; m_aw_addr = '0;
    s_aw_ready = 2'b11; s_b_valid = 2'b00; s_b_id = '0; s_b_resp = '0; m_b_ready = 1'b1;
    do_reset();

    // R3/R4/R8: every identifier, every split of three writes over both targets
    for (int id = 0; id < 4; id++) begin
      for (int pat = 0; pat < 8; pat++) begin
        for (int j = 0; j < 3; j++) begin
          dest[j] = (pat >> j) & 1;
          do_aw(id, dest[j], 1, "R3");
        end
        k = 0;
        while (k < 3) begin
          @(negedge clk);
          for (int s = 0; s < 2; s++) begin
            int nx;
            nx = next_for(s);
            s_b_valid[s] = (nx < 3);
            s_b_id[2*s +: 2] = 2'(id);
            s_b_resp[2*s +: 2] = 2'(nx);
          end
          #2;
          chk("R3 valid", int'(m_b_valid), 1);
          chk("R4 only owed target ready", int'(s_b_ready), 1 << dest[k]);
          chk("R3 order", int'(m_b_resp), k);
          chk("R8 id", int'(m_b_id), id);
          @(posedge clk);
          #1 k++;
        end
        s_b_valid = 2'b00;
      end
    end

    // R4: early completion from the wrong target is held
    do_aw(0, 0, 1, "R4");
    do_aw(0, 1, 1, "R4");
    @(negedge clk);
    s_b_valid = 2'b10; s_b_id = 4'b0000; s_b_resp = 4'b0100;
    #2;
    chk("R4 early held valid", int'(m_b_valid), 0);
    chk("R4 early held ready", int'(s_b_ready), 0);
    @(negedge clk);
    s_b_valid = 2'b00;
    one_b(0, 0, 2, "R4");
    one_b(1, 0, 1, "R4");

    // R5: identifiers are independent
    do_aw(0, 0, 1, "R5");
    do_aw(1, 1, 1, "R5");
    one_b(1, 1, 3, "R5");
    one_b(0, 0, 0, "R5");

    // R6: full identifier refused, others accepted, slot freed by a completion
    for (int j = 0; j < 4; j++) do_aw(2, 0, 1, "R6");
    @(negedge clk);
    m_aw_valid = 1'b1; m_aw_id = 2'd2; m_aw_addr = addr_for(2, 1);
    #2;
    chk("R6 full ready", int'(m_aw_ready), 0);
    chk("R6 full valid", int'(s_aw_valid), 0);
    m_aw_id = 2'd3; m_aw_addr = addr_for(3, 0);
    #1;
    chk("R6 other id ready", int'(m_aw_ready), 1);
    @(posedge clk);
    #1 m_aw_valid = 1'b0;
    one_b(0, 2, 2, "R6");
    do_aw(2, 0, 1, "R6 slot freed");
    for (int j = 0; j < 4; j++) one_b(0, 2, j, "R6");
    one_b(0, 3, 1, "R6");

    // R10: stalled target blocks acceptance
    s_aw_ready = 2'b01;
    @(negedge clk);
    m_aw_valid = 1'b1; m_aw_id = 2'd1; m_aw_addr = addr_for(1, 1);
    #2;
    chk("R10 ready follows target", int'(m_aw_ready), 0);
    chk("R10 valid offered", int'(s_aw_valid), 2);
    @(negedge clk);
    m_aw_valid = 1'b0; s_aw_ready = 2'b11;

    // R7/R9: fresh reset, round-robin from target 0, then backpressure
    do_reset();
    do_aw(0, 0, 1, "R7");
    do_aw(1, 1, 1, "R7");
    do_aw(0, 0, 1, "R7");
    do_aw(1, 1, 1, "R7");
    @(negedge clk);
    m_b_ready = 1'b0;
    s_b_valid = 2'b11; s_b_id = 4'b0100; s_b_resp = 4'b1101;
    #2;
    chk("R9 no ready", int'(s_b_ready), 0);
    chk("R9 offered", int'(m_b_valid), 1);
    @(negedge clk);
    #2;
    chk("R9 still target 0", int'(m_b_resp), 1);
    m_b_ready = 1'b1;
    #1;
    chk("R7 first grant", int'(s_b_ready), 1);
    @(negedge clk);
    s_b_resp = 4'b1110;
    #2;
    chk("R7 second grant", int'(s_b_ready), 2);
    chk("R7 second resp", int'(m_b_resp), 3);
    @(negedge clk);
    s_b_resp = 4'b0010;
    #2;
    chk("R7 third grant", int'(s_b_ready), 1);
    chk("R7 third id", int'(m_b_id), 0);
    @(negedge clk);
    s_b_valid = 2'b10;
    #2;
    chk("R7 fourth grant", int'(s_b_ready), 2);
    @(negedge clk);
    s_b_valid = 2'b00;
    #2;
    chk("R3 drained", int'(m_b_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule